// File: doc/BRIEF.md
# Indexed Clock Register File

This block holds 128 bytes of clock, calendar, control and general storage. A host reaches them through a two-address port. A write to the even address chooses which byte is addressed. An access at the odd address then reads or writes that byte. Some bytes follow their own access rules:

- **Control byte at index 10.** Its busy flag in bit 7 cannot be changed from the bus.
- **Control byte at index 11.** Setting its freeze bit (bit 7) stops updates.
- **Flag byte at index 12.** It is read-only, and reading it clears it.
- **Status byte at index 13.** It is read-only.

A separate time engine keeps the time and calendar bytes up to date. It also raises flags through a side write port. That port writes any byte without these restrictions.

The interrupt output follows the summary flag of the flag byte. The block has two kinds of reset:

- **Power-up reset.** It loads the fixed start values.
- **System reset.** It clears only the interrupt enables and the flags.

Top module: `cmos_regfile`

## Requirements
- R1: A bus write at the even address (bus_addr = 0) loads the index with bus_wdata[6:0]. bus_wdata[7] is dropped.
- R2: While a read is strobed, bus_rdata is 0xFF at the even address. At the odd address it is the byte the index selects, in the same cycle.
- R3: A bus write to index 10 stores the new bits 6:0 and keeps the old bit 7 of that byte.
- R4: Bus writes to index 12 and index 13 leave those bytes unchanged.
- R5: While index 12 is read, bus_rdata shows its current value. On the first clock edge at which the odd-address read strobe is seen low again, the byte becomes 0x00 and irq goes low.
- R6: A bus write to index 11 with bit 7 set stores the data with bit 4 forced to 0. In the same edge it clears bit 7 of index 10.
- R7: After power-up reset these values hold:
  - index 10 = 0x26, index 11 = 0x02, index 12 = 0x00, index 13 = 0x80;
  - every other byte = 0x00;
  - the index = 0, and irq is low.
- R8: A one-cycle system reset (soft_rst) has these effects:
  - index 11: bits 6, 5 and 3 are cleared;
  - index 12: bits 7:4 are cleared;
  - irq goes low;
  - every other byte and bit keeps its value.
- R9: An eng_we write stores eng_wdata verbatim at any index, including bit 7 of index 10 and indexes 12 and 13. When a bus write targets the same index in the same cycle, the engine value is the one kept.
- R10: irq equals bit 7 of the byte at index 12 at all times.
- R11: A bus write to any index other than 10 to 13 stores the data byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, asynchronous, active low |
| soft_rst | input | 1 | System reset, one clocked pulse |
| bus_cs | input | 1 | Bus access select |
| bus_addr | input | 1 | 0 = index address, 1 = data address |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_re | input | 1 | Read strobe, held for the length of the read |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data, combinational |
| eng_we | input | 1 | Time-engine write enable |
| eng_idx | input | 7 | Time-engine target index |
| eng_wdata | input | 8 | Time-engine write data |
| irq | output | 1 | Interrupt request |

## Verification
The properties make three assumptions about the inputs:

- **System reset.** It is never asserted in the same cycle as an engine write to the flag byte.
- **Flag-byte clear.** The engine does not write the flag byte in the cycle when the clear takes effect.
- **Index changes during a read.** The index is not changed while a read of the flag byte is in progress.

The stimulus keeps to these assumptions by running one operation at a time. Each read is a strobe cycle followed by an idle cycle, in which the clear takes effect. Engine writes, system resets and bus accesses each get cycles of their own. The one exception is a directed case that puts a bus write and an engine write on the same index in one cycle, on a byte other than the flag byte.

// File: rtl/cmosrf_pkg.sv
package cmosrf_pkg;

    localparam int REG_BYTES = 128;
    localparam int DW        = 8;
    localparam int IDXW      = $clog2(REG_BYTES);

    localparam logic [IDXW-1:0] IDX_CTLA  = IDXW'(10);
    localparam logic [IDXW-1:0] IDX_CTLB  = IDXW'(11);
    localparam logic [IDXW-1:0] IDX_FLAGS = IDXW'(12);
    localparam logic [IDXW-1:0] IDX_STAT  = IDXW'(13);

    localparam int CTLA_BUSY  = 7;
    localparam int CTLB_FRZ   = 7;
    localparam int CTLB_UPDEN = 4;
    localparam int FLAG_SUM   = 7;

    localparam logic [DW-1:0] CTLB_SOFT_KEEP  = 8'h97;
    localparam logic [DW-1:0] FLAGS_SOFT_KEEP = 8'h0F;

    typedef struct packed {
        logic            wr_en;
        logic [IDXW-1:0] wr_idx;
        logic [DW-1:0]   wr_val;
        logic            clr_busy;
    } bus_wr_t;

    typedef struct packed {
        logic [IDXW-1:0] idx;
        logic            rd_flags;
    } port_state_t;

    function automatic logic [DW-1:0] power_value(input logic [IDXW-1:0] i);
        case (i)
            IDX_CTLA: return 8'h26;
            IDX_CTLB: return 8'h02;
            IDX_STAT: return 8'h80;
            default:  return 8'h00;
        endcase
    endfunction

    function automatic logic [DW-1:0] soft_keep(input logic [IDXW-1:0] i);
        case (i)
            IDX_CTLB:  return CTLB_SOFT_KEEP;
            IDX_FLAGS: return FLAGS_SOFT_KEEP;
            default:   return '1;
        endcase
    endfunction

endpackage

// File: rtl/cmosrf_port.sv
module cmosrf_port
    import cmosrf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_cs,
    input  logic            bus_addr,
    input  logic            bus_we,
    input  logic            bus_re,
    input  logic [IDXW-1:0] wdata_idx,
    output logic [IDXW-1:0] idx,
    output logic            data_wr,
    output logic            clr_flags
);

    port_state_t st_q, st_d;
    logic        rd_flags_now;

    always_comb begin
        st_d         = st_q;
        rd_flags_now = bus_cs && bus_re && bus_addr && (st_q.idx == IDX_FLAGS);
        if (bus_cs && bus_we && !bus_addr) begin
            st_d.idx = wdata_idx;
        end
        st_d.rd_flags = rd_flags_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx       = st_q.idx;
    assign data_wr   = bus_cs && bus_we && bus_addr;
    assign clr_flags = st_q.rd_flags && !rd_flags_now;

endmodule

// File: rtl/cmosrf_rules.sv
module cmosrf_rules
    import cmosrf_pkg::*;
(
    input  logic            data_wr,
    input  logic [IDXW-1:0] idx,
    input  logic [DW-1:0]   wdata,
    input  logic            a_busy,
    output bus_wr_t         bw
);

    always_comb begin
        bw          = '0;
        bw.wr_idx   = idx;
        bw.wr_val   = wdata;
        if (data_wr) begin
            case (idx)
                IDX_CTLA: begin
                    bw.wr_en             = 1'b1;
                    bw.wr_val[CTLA_BUSY] = a_busy;
                end
                IDX_CTLB: begin
                    bw.wr_en = 1'b1;
                    if (wdata[CTLB_FRZ]) begin
                        bw.wr_val[CTLB_UPDEN] = 1'b0;
                        bw.clr_busy           = 1'b1;
                    end
                end
                IDX_FLAGS, IDX_STAT: begin
                    bw.wr_en = 1'b0;
                end
                default: begin
                    bw.wr_en = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/cmosrf_store.sv
module cmosrf_store
    import cmosrf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst,
    input  bus_wr_t         bw,
    input  logic            clr_flags,
    input  logic            eng_we,
    input  logic [IDXW-1:0] eng_idx,
    input  logic [DW-1:0]   eng_wdata,
    input  logic [IDXW-1:0] rd_idx,
    output logic [DW-1:0]   rd_byte,
    output logic [DW-1:0]   reg_a,
    output logic [DW-1:0]   reg_b,
    output logic [DW-1:0]   reg_c,
    output logic [DW-1:0]   reg_d
);

    logic [DW-1:0] bytes_w [REG_BYTES];

    for (genvar g = 0; g < REG_BYTES; g++) begin : g_byte
        localparam logic [IDXW-1:0] SELF = IDXW'(g);
        logic [DW-1:0] byte_q, byte_d;

        always_comb begin
            byte_d = byte_q;
            if (bw.clr_busy && SELF == IDX_CTLA) begin
                byte_d[CTLA_BUSY] = 1'b0;
            end
            if (clr_flags && SELF == IDX_FLAGS) begin
                byte_d = '0;
            end
            if (bw.wr_en && bw.wr_idx == SELF) begin
                byte_d = bw.wr_val;
            end
            if (eng_we && eng_idx == SELF) begin
                byte_d = eng_wdata;
            end
            if (soft_rst) begin
                byte_d = byte_d & soft_keep(SELF);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= power_value(SELF);
            end else begin
                byte_q <= byte_d;
            end
        end

        assign bytes_w[g] = byte_q;
    end

    assign rd_byte = bytes_w[rd_idx];
    assign reg_a   = bytes_w[IDX_CTLA];
    assign reg_b   = bytes_w[IDX_CTLB];
    assign reg_c   = bytes_w[IDX_FLAGS];
    assign reg_d   = bytes_w[IDX_STAT];

endmodule

// File: rtl/cmos_regfile.sv
module cmos_regfile
    import cmosrf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst,
    input  logic            bus_cs,
    input  logic            bus_addr,
    input  logic            bus_we,
    input  logic            bus_re,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic            eng_we,
    input  logic [IDXW-1:0] eng_idx,
    input  logic [DW-1:0]   eng_wdata,
    output logic            irq
);

    logic [IDXW-1:0] port_idx;
    logic            data_wr;
    logic            clr_flags;
    bus_wr_t         bw;
    logic [DW-1:0]   rd_byte;
    logic [DW-1:0]   reg_a, reg_b, reg_c, reg_d;

    cmosrf_port u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_cs    (bus_cs),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .wdata_idx (bus_wdata[IDXW-1:0]),
        .idx       (port_idx),
        .data_wr   (data_wr),
        .clr_flags (clr_flags)
    );

    cmosrf_rules u_rules (
        .data_wr (data_wr),
        .idx     (port_idx),
        .wdata   (bus_wdata),
        .a_busy  (reg_a[CTLA_BUSY]),
        .bw      (bw)
    );

    cmosrf_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .bw        (bw),
        .clr_flags (clr_flags),
        .eng_we    (eng_we),
        .eng_idx   (eng_idx),
        .eng_wdata (eng_wdata),
        .rd_idx    (port_idx),
        .rd_byte   (rd_byte),
        .reg_a     (reg_a),
        .reg_b     (reg_b),
        .reg_c     (reg_c),
        .reg_d     (reg_d)
    );

    assign bus_rdata = bus_addr ? rd_byte : '1;
    assign irq       = reg_c[FLAG_SUM];

endmodule

// File: rtl/cmos_regfile_chk.sv
module cmos_regfile_chk
    import cmosrf_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            soft_rst,
    input logic            bus_cs,
    input logic            bus_addr,
    input logic            bus_we,
    input logic            bus_re,
    input logic [DW-1:0]   bus_wdata,
    input logic            eng_we,
    input logic [IDXW-1:0] eng_idx,
    input logic [IDXW-1:0] idx,
    input logic [DW-1:0]   reg_a,
    input logic [DW-1:0]   reg_b,
    input logic [DW-1:0]   reg_c,
    input logic [DW-1:0]   reg_d,
    input logic            irq
);

    logic rd_c_now, rd_c_seen_q;
    logic wr_odd, eng_a, eng_b, eng_c;

    assign rd_c_now = bus_cs && bus_re && bus_addr && idx == IDX_FLAGS;
    assign wr_odd   = bus_cs && bus_we && bus_addr;
    assign eng_a    = eng_we && eng_idx == IDX_CTLA;
    assign eng_b    = eng_we && eng_idx == IDX_CTLB;
    assign eng_c    = eng_we && eng_idx == IDX_FLAGS;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_c_seen_q <= 1'b0;
        end else begin
            rd_c_seen_q <= rd_c_now;
        end
    end

    assert_index_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_we && !bus_addr) |=> idx == $past(bus_wdata[IDXW-1:0]));

    assert_busy_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_odd && idx == IDX_CTLA && !eng_a)
        |=> reg_a[CTLA_BUSY] == $past(reg_a[CTLA_BUSY]));

    assert_status_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_we && eng_idx == IDX_STAT) |=> $stable(reg_d));

    assert_flags_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_odd && idx == IDX_FLAGS && !eng_c && !soft_rst && !rd_c_seen_q)
        |=> $stable(reg_c));

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_c_seen_q && !rd_c_now && !eng_c) |=> (reg_c == '0 && !irq));

    assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_odd && idx == IDX_CTLB && bus_wdata[CTLB_FRZ] && !eng_a && !eng_b)
        |=> (!reg_a[CTLA_BUSY] && !reg_b[CTLB_UPDEN]));

    assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> ((reg_b & ~CTLB_SOFT_KEEP) == '0
                      && (reg_c & ~FLAGS_SOFT_KEEP) == '0 && !irq));

    assert_irq_tracks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> reg_c[FLAG_SUM]);

endmodule

bind cmos_regfile cmos_regfile_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .bus_cs    (bus_cs),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_wdata (bus_wdata),
    .eng_we    (eng_we),
    .eng_idx   (eng_idx),
    .idx       (port_idx),
    .reg_a     (reg_a),
    .reg_b     (reg_b),
    .reg_c     (reg_c),
    .reg_d     (reg_d),
    .irq       (irq)
);

// File: tb/cmos_regfile_test.sv
module cmos_regfile_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n, soft_rst, bus_cs, bus_addr, bus_we, bus_re, eng_we, irq;
    logic [7:0] bus_wdata, bus_rdata, eng_wdata;
    logic [6:0] eng_idx;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] mem [128];
    logic [6:0] m_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmos_regfile uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bus_cs(bus_cs),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_we(eng_we),
        .eng_idx(eng_idx), .eng_wdata(eng_wdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic idle();
        soft_rst = 0; bus_cs = 0; bus_addr = 0; bus_we = 0; bus_re = 0;
        bus_wdata = 0; eng_we = 0; eng_idx = 0; eng_wdata = 0;
    endtask

    function automatic logic [7:0] start_val(input int i);
        case (i)
            10: return 8'h26;
            11: return 8'h02;
            13: return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_bus_write(input logic [6:0] i, input logic [7:0] v);
        case (i)
            7'd10: mem[10] = {mem[10][7], v[6:0]};
            7'd11: begin
                if (v[7]) begin
                    mem[10][7] = 1'b0;
                    mem[11]    = v & 8'hEF;
                end else begin
                    mem[11] = v;
                end
            end
            7'd12, 7'd13: ;
            default: mem[i] = v;
        endcase
    endtask

    task automatic set_idx(input logic [6:0] i, input logic hi);
        bus_cs = 1; bus_we = 1; bus_addr = 0; bus_wdata = {hi, i};
        @(negedge clk); idle();
        m_idx = i;
    endtask

    task automatic wr_data(input logic [7:0] v);
        bus_cs = 1; bus_we = 1; bus_addr = 1; bus_wdata = v;
        @(negedge clk); idle();
        model_bus_write(m_idx, v);
    endtask

    task automatic rd_data(input string tag);
        bus_cs = 1; bus_re = 1; bus_addr = 1;
        #1;
        check(tag, bus_rdata, mem[m_idx]);
        check("R10", {7'd0, irq}, {7'd0, mem[12][7]});
        @(negedge clk); idle();
        @(negedge clk);
        if (m_idx == 7'd12) mem[12] = 8'h00;
    endtask

    task automatic rd_even();
        bus_cs = 1; bus_re = 1; bus_addr = 0;
        #1;
        check("R2 even", bus_rdata, 8'hFF);
        @(negedge clk); idle();
    endtask

    task automatic eng_wr(input logic [6:0] i, input logic [7:0] v);
        eng_we = 1; eng_idx = i; eng_wdata = v;
        @(negedge clk); idle();
        mem[i] = v;
    endtask

    task automatic soft_pulse();
        soft_rst = 1;
        @(negedge clk); idle();
        mem[11] = mem[11] & 8'h97;
        mem[12] = mem[12] & 8'h0F;
    endtask

    task automatic peek(input logic [6:0] i, input string tag);
        set_idx(i, 1'b0);
        rd_data(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_junk;
        seed_junk = $urandom(32'h5eed1);
        idle();
        rst_n = 0;
        for (int i = 0; i < 128; i++) mem[i] = start_val(i);
        m_idx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R7 power-up state (index 0 selected)
        check("R7 irq", {7'd0, irq}, 8'd0);
        rd_data("R7 idx0");
        peek(10, "R7 A"); peek(11, "R7 B"); peek(12, "R7 C"); peek(13, "R7 D");
        rd_even();

        // R1: bit 7 of index data dropped; R11 verbatim store
        set_idx(7'd5, 1'b1);
        wr_data(8'h3C);
        rd_data("R1 R11");

        // R3 busy bit kept on bus writes
        set_idx(10, 1'b0); wr_data(8'hFF); rd_data("R3 keep0");
        eng_wr(10, 8'hA6);
        set_idx(10, 1'b0); rd_data("R9 busy"); wr_data(8'h00); rd_data("R3 keep1");

        // R4 read-only bytes
        set_idx(13, 1'b0); wr_data(8'h00); rd_data("R4 D");
        eng_wr(12, 8'h30);
        set_idx(12, 1'b0); wr_data(8'hFF); rd_data("R4 C");

        // R6 freeze bit
        eng_wr(10, 8'h80);
        set_idx(11, 1'b0); wr_data(8'h92); rd_data("R6 B");
        peek(10, "R6 A");
        set_idx(11, 1'b0); wr_data(8'h12); rd_data("R6 B free");

        // R5 / R10 read clears flags
        eng_wr(12, 8'hF0);
        check("R10 irq high", {7'd0, irq}, 8'd1);
        set_idx(12, 1'b0); rd_data("R5 value"); rd_data("R5 cleared");
        check("R5 irq low", {7'd0, irq}, 8'd0);

        // R9 engine beats bus on same index
        set_idx(20, 1'b0);
        bus_cs = 1; bus_we = 1; bus_addr = 1; bus_wdata = 8'h11;
        eng_we = 1; eng_idx = 20; eng_wdata = 8'h22;
        @(negedge clk); idle();
        model_bus_write(20, 8'h11); mem[20] = 8'h22;
        rd_data("R9 collide");

        // R8 system reset
        set_idx(11, 1'b0); wr_data(8'h7E);
        eng_wr(12, 8'hFF);
        soft_pulse();
        check("R8 irq", {7'd0, irq}, 8'd0);
        peek(11, "R8 B"); peek(12, "R8 C"); peek(10, "R8 A"); peek(5, "R8 other");

        // constrained random mix
        for (int n = 0; n < 800; n++) begin
            int op;
            op = $urandom_range(0, 9);
            case (op)
                0, 1: set_idx(($urandom_range(0, 3) != 0) ? 7'($urandom_range(0, 15))
                                                          : 7'($urandom_range(0, 127)),
                              1'($urandom_range(0, 1)));
                2, 3: wr_data(8'($urandom_range(0, 255)));
                4, 5, 6: rd_data("R2 rand");
                7: eng_wr(($urandom_range(0, 1) != 0) ? 7'($urandom_range(10, 13))
                                                      : 7'($urandom_range(0, 127)),
                          8'($urandom_range(0, 255)));
                8: rd_even();
                default: if ($urandom_range(0, 3) == 0) soft_pulse();
            endcase
        end
        for (int i = 0; i < 16; i++) peek(7'(i), "R11 sweep");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule